// File: doc/BRIEF.md
# Lane-Selectable Link Event Counter

This block counts one chosen event of a serial link controller on one chosen lane. The controller's event sources arrive as a flat vector of single-cycle pulses, one bit for every combination of event group, event number within the group, and lane. Software picks the combination through a control register, starts and stops counting with a multi-bit enable command, and zeroes the count with a separate clear command. The running value is read from a data register.

The count never resets by itself. Stopping freezes it, restarting carries on from the frozen value, and changing the selection leaves it alone. A new measurement therefore begins with an explicit clear. The counter is `CNT_W` bits wide and wraps silently, so software takes differences modulo 2^`CNT_W`.

Both registers sit at fixed offsets from the block's base on a simple 32-bit register bus. Writes take effect at the clock edge where the write is presented. Read data is registered and appears one cycle after the read strobe.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count is 0, counting is stopped, and the selection fields are 0. Reads of the control register (offset `CTRL_OFS`, 0x08) and the data register (offset `DATA_OFS`, 0x0C) both return 0.
- R2: A write to the control register stores the group in bits 27:24, the event number in bits 23:16 and the lane in bits 11:8. A read returns those three fields in the same positions. Bits 31:28, 15:12, 6:0 read as 0, so the command fields in bits 4:0 always read back as zero.
- R3: The enable command is control bits 4:2. The value 3'b011 starts counting and 3'b001 stops it, each from the edge of the write. Any other value leaves the run state unchanged. Control bit 7 reads 1 while counting runs and 0 while it is stopped.
- R4: While counting runs, the count rises by exactly 1 in every cycle where `evtPulse[(group*NUM_EVENTS + event)*NUM_LANES + lane]` is 1. Pulses on any other bit do not count. A pulse presented in the same cycle as the starting write is not counted.
- R5: The clear command is control bits 1:0. Writing 2'b01 makes the count 0 at the edge of the write, even if a selected pulse arrives in that same cycle. The values 2'b00, 2'b10 and 2'b11 do not change the count.
- R6: The count never clears by itself. Stopping holds the value, and a later restart without a clear continues from that value.
- R7: Nothing is counted if the lane field is `NUM_LANES` (4) or more, the group field is `NUM_GROUPS` (8) or more, or the event field is `NUM_EVENTS` (20) or more. This holds whatever the pulse vector carries.
- R8: The count wraps from 2^`CNT_W`-1 to 0.
- R9: A read of the data register returns the count, zero-extended to 32 bits, one cycle after the read strobe. Writes to the data register or to any other offset change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register offset from the block base |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after `regRdEn` |
| evtPulse | input | NUM_GROUPS*NUM_EVENTS*NUM_LANES | One-cycle event pulses, index (group*NUM_EVENTS+event)*NUM_LANES+lane |

## Verification
Two cases are hard to reach from the ports. The first is a clear that meets a selected pulse in the very same cycle. The bench raises the pulse bit at the same falling edge where it presents the clearing write, so both reach the counter at one rising edge. The second is the silent wrap. A full 32-bit wrap is out of reach in a short run, so the bench drives a second instance with a 4-bit count in parallel on the same bus. Pushing 18 pulses through it must give 2 where the wide counter gives 18. Out-of-range selections are checked by driving every pulse bit high at once, so any leak into the count shows up.

// File: rtl/lec_pkg.sv
package lec_pkg;

  // control register field positions (software-visible layout)
  localparam int GRP_LSB   = 24;
  localparam int GRP_W     = 4;
  localparam int EVT_LSB   = 16;
  localparam int EVT_W     = 8;
  localparam int LANE_LSB  = 8;
  localparam int LANE_W    = 4;
  localparam int STAT_BIT  = 7;
  localparam int ENCMD_LSB = 2;
  localparam int ENCMD_W   = 3;
  localparam int CLRCMD_LSB = 0;
  localparam int CLRCMD_W  = 2;

  localparam logic [ENCMD_W-1:0]  EN_CMD_START = 3'b011;
  localparam logic [ENCMD_W-1:0]  EN_CMD_STOP  = 3'b001;
  localparam logic [CLRCMD_W-1:0] CLR_CMD_ZERO = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero the count this edge
    logic run;     // counting enabled
    logic selOk;   // selection addresses an existing source
  } lecStrobe_t;

endpackage

// File: rtl/lec_ctrl.sv
module lec_ctrl
  import lec_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_EVENTS = 20,
  parameter int NUM_LANES  = 4,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 10,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [31:0]       regRdData,
  output lecStrobe_t        strobes,
  output logic [IDX_W-1:0]  selIdx
);

  logic [GRP_W-1:0]  groupQ;
  logic [EVT_W-1:0]  eventQ;
  logic [LANE_W-1:0] laneQ;
  logic              runQ;

  logic              wrCtrl;
  logic [ENCMD_W-1:0]  enCmd;
  logic [CLRCMD_W-1:0] clrCmd;
  logic [31:0]       flatIdx;
  logic              unusedWrBits;

  assign wrCtrl = regWrEn && (regAddr == CTRL_OFS);
  assign enCmd  = regWrData[ENCMD_LSB +: ENCMD_W];
  assign clrCmd = regWrData[CLRCMD_LSB +: CLRCMD_W];
  assign unusedWrBits = ^{regWrData[31:28], regWrData[15:12], regWrData[7:5]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupQ <= '0;
      eventQ <= '0;
      laneQ  <= '0;
      runQ   <= 1'b0;
    end else if (wrCtrl) begin
      groupQ <= regWrData[GRP_LSB +: GRP_W];
      eventQ <= regWrData[EVT_LSB +: EVT_W];
      laneQ  <= regWrData[LANE_LSB +: LANE_W];
      if (enCmd == EN_CMD_START)     runQ <= 1'b1;
      else if (enCmd == EN_CMD_STOP) runQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.clear = wrCtrl && (clrCmd == CLR_CMD_ZERO);
    strobes.run   = runQ;
    strobes.selOk = (32'(groupQ) < NUM_GROUPS) &&
                    (32'(eventQ) < NUM_EVENTS) &&
                    (32'(laneQ)  < NUM_LANES);
    flatIdx = (32'(groupQ) * NUM_EVENTS + 32'(eventQ)) * NUM_LANES + 32'(laneQ);
    selIdx  = strobes.selOk ? flatIdx[IDX_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (regRdEn) begin
      regRdData <= '0;
      if (regAddr == CTRL_OFS) begin
        regRdData[GRP_LSB +: GRP_W]   <= groupQ;
        regRdData[EVT_LSB +: EVT_W]   <= eventQ;
        regRdData[LANE_LSB +: LANE_W] <= laneQ;
        regRdData[STAT_BIT]           <= runQ;
      end else if (regAddr == DATA_OFS) begin
        regRdData <= 32'(cntVal);
      end
    end
  end

endmodule

// File: rtl/lec_datapath.sv
module lec_datapath
  import lec_pkg::*;
#(
  parameter int NUM_SRC = 640,
  parameter int IDX_W   = 10,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  lecStrobe_t         strobes,
  input  logic [IDX_W-1:0]   selIdx,
  input  logic [NUM_SRC-1:0] evtPulse,
  output logic [CNT_W-1:0]   cntVal
);

  logic [NUM_SRC-1:0] hitVec;
  logic               hit;

  // one-hot match of the selected source; OR-reduced to a single hit
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hitVec[i] = evtPulse[i] && (selIdx == IDX_W'(i));
  end

  assign hit = strobes.run && strobes.selOk && (|hitVec);

  always_ff @(posedge clk) begin
    if (!rstN)              cntVal <= '0;
    else if (strobes.clear) cntVal <= '0;
    else if (hit)           cntVal <= cntVal + 1'b1;
  end

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
  import lec_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_EVENTS = 20,
  parameter int NUM_LANES  = 4,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h0C,
  localparam int NUM_SRC = NUM_GROUPS * NUM_EVENTS * NUM_LANES,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] evtPulse
);

  lecStrobe_t         strobes;
  logic [IDX_W-1:0]   selIdx;
  logic [CNT_W-1:0]   cntVal;
  logic               runLvl;
  logic               selOk;

  assign runLvl = strobes.run;
  assign selOk  = strobes.selOk;

  lec_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_EVENTS(NUM_EVENTS), .NUM_LANES(NUM_LANES),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .cntVal(cntVal),
    .regRdData(regRdData), .strobes(strobes), .selIdx(selIdx)
  );

  lec_datapath #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selIdx(selIdx),
    .evtPulse(evtPulse), .cntVal(cntVal)
  );

endmodule

// File: rtl/lane_evt_counter_chk.sv
module lane_evt_counter_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h08
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic [CNT_W-1:0]  cntVal,
  input logic              runLvl,
  input logic              selOk
);

  logic ctrlWr, clrWr, startWr;
  assign ctrlWr  = regWrEn && (regAddr == CTRL_OFS);
  assign clrWr   = ctrlWr && (regWrData[1:0] == 2'b01);
  assign startWr = ctrlWr && (regWrData[4:2] == 3'b011);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> (cntVal == '0));

  assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> runLvl);

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runLvl && !clrWr) |=> $stable(cntVal));

  assert_bad_sel_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!selOk && !clrWr) |=> $stable(cntVal));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1)));

  assert_status_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == CTRL_OFS) |=>
      ((regRdData[7] == $past(runLvl)) && (regRdData[6:0] == 7'd0)));

endmodule

bind lane_evt_counter lane_evt_counter_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .cntVal(cntVal), .runLvl(runLvl), .selOk(selOk)
);

// File: tb/lane_evt_counter_tb.sv
module lane_evt_counter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 8, NE = 20, NL = 4;
  localparam int NSRC = NG * NE * NL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdMain, rdSmall;
  logic [NSRC-1:0] evtPulse = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_evt_counter u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdMain),
    .evtPulse(evtPulse)
  );

  lane_evt_counter #(.CNT_W(4)) u_small (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdSmall),
    .evtPulse(evtPulse)
  );

  function automatic logic [31:0] ctrlWord(int g, int e, int l, int en, int clr);
    return (32'(g) << 24) | (32'(e) << 16) | (32'(l) << 8) | (32'(en) << 2) | 32'(clr);
  endfunction

  function automatic int srcIdx(int g, int e, int l);
    return (g * NE + e) * NL + l;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] dMain, output logic [31:0] dSmall);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    dMain = rdMain; dSmall = rdSmall;
  endtask

  task automatic pulse(int idx, int n);
    evtPulse[idx] = 1'b1;
    repeat (n) begin @(posedge clk); @(negedge clk); end
    evtPulse = '0;
  endtask

  task automatic pulseAll(int n);
    evtPulse = '1;
    repeat (n) begin @(posedge clk); @(negedge clk); end
    evtPulse = '0;
  endtask

  logic [31:0] d, ds;

  task automatic t_reset;
    rdReg(8'h08, d, ds); check("R1 ctrl after reset", d, 32'h0);
    rdReg(8'h0C, d, ds); check("R1 count after reset", d, 32'h0);
  endtask

  task automatic t_fields;
    wrReg(8'h08, ctrlWord(3, 8'h12, 2, 0, 0));
    rdReg(8'h08, d, ds); check("R2 field readback", d, 32'h0312_0200);
    wrReg(8'h08, ctrlWord(7, 8'h13, 3, 7, 3) | 32'hF000_F0E0);
    rdReg(8'h08, d, ds); check("R2 cmd bits read zero, R3 no-op enable", d, 32'h0713_0300);
    rdReg(8'h0C, d, ds); check("R5 clear 2'b11 ignored", d, 32'h0);
  endtask

  task automatic t_count;
    wrReg(8'h08, ctrlWord(1, 5, 1, 3, 1));
    rdReg(8'h08, d, ds); check("R3 status on", d, 32'h0105_0180);
    pulse(srcIdx(1, 5, 1), 5);
    rdReg(8'h0C, d, ds); check("R4 five pulses", d, 32'd5);
    pulse(srcIdx(1, 5, 2), 3);
    pulse(srcIdx(1, 6, 1), 2);
    rdReg(8'h0C, d, ds); check("R4 other sources ignored", d, 32'd5);
  endtask

  task automatic t_hold;
    wrReg(8'h08, ctrlWord(1, 5, 1, 1, 0));
    rdReg(8'h08, d, ds); check("R3 status off", d, 32'h0105_0100);
    pulse(srcIdx(1, 5, 1), 4);
    rdReg(8'h0C, d, ds); check("R6 held while stopped", d, 32'd5);
    // start write with a coincident pulse: that pulse is not counted
    evtPulse[srcIdx(1, 5, 1)] = 1'b1;
    wrReg(8'h08, ctrlWord(1, 5, 1, 3, 0));
    evtPulse = '0;
    pulse(srcIdx(1, 5, 1), 2);
    rdReg(8'h0C, d, ds); check("R6 resume without clear, R4 start-cycle pulse", d, 32'd7);
  endtask

  task automatic t_clear;
    evtPulse[srcIdx(1, 5, 1)] = 1'b1;
    wrReg(8'h08, ctrlWord(1, 5, 1, 0, 1));
    evtPulse = '0;
    rdReg(8'h0C, d, ds); check("R5 clear beats coincident pulse", d, 32'd0);
    pulse(srcIdx(1, 5, 1), 3);
    wrReg(8'h08, ctrlWord(1, 5, 1, 0, 2));
    rdReg(8'h0C, d, ds); check("R5 clear 2'b10 ignored", d, 32'd3);
  endtask

  task automatic t_regmap;
    wrReg(8'h0C, 32'hFFFF_FFFF);
    wrReg(8'h10, 32'hFFFF_FFFF);
    rdReg(8'h0C, d, ds); check("R9 data write ignored", d, 32'd3);
    rdReg(8'h08, d, ds); check("R9 stray write ignored", d, 32'h0105_0180);
    rdReg(8'h10, d, ds); check("R9 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_range;
    wrReg(8'h08, ctrlWord(0, 0, 5, 3, 1));
    pulseAll(3);
    rdReg(8'h0C, d, ds); check("R7 lane out of range", d, 32'd0);
    wrReg(8'h08, ctrlWord(0, 20, 0, 3, 0));
    pulseAll(3);
    rdReg(8'h0C, d, ds); check("R7 event out of range", d, 32'd0);
    wrReg(8'h08, ctrlWord(8, 0, 0, 3, 0));
    pulseAll(3);
    rdReg(8'h0C, d, ds); check("R7 group out of range", d, 32'd0);
  endtask

  task automatic t_wrap;
    wrReg(8'h08, ctrlWord(0, 0, 0, 3, 1));
    pulse(0, 18);
    rdReg(8'h0C, d, ds);
    check("R8 wide count", d, 32'd18);
    check("R8 narrow count wraps", ds, 32'd2);
    wrReg(8'h08, ctrlWord(7, 19, 3, 3, 1));
    pulse(srcIdx(7, 19, 3), 4);
    rdReg(8'h0C, d, ds); check("R4 highest source", d, 32'd4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_count();
    t_hold();
    t_clear();
    t_regmap();
    t_range();
    t_wrap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule